// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block sequences program and erase operations on a small on-chip flash array. The array is modelled inside the block as a bank of rows, each 128 bits wide. Software configures the block through a control register. That register holds a program-enable bit, a sector-erase bit, a whole-array erase bit, a target sector number and a programming width. A self-clearing go bit in the same register launches an erase. A status register reports a busy bit and three sticky error flags.

Data to be programmed arrives on a memory-write stream. Each beat carries a byte address, up to 64 bits of data and an access size. A program never sets a bit: the stored bytes become the old value ANDed with the new value, and only an erase returns bits to 1. Each write is checked against the row boundary and against the configured width. Each kind of rule violation raises its own flag, and a rejected write leaves the array untouched.

Busy lasts a fixed, parameter-set number of cycles for each operation kind, so software and benches can predict exactly when it ends. The stream has a valid/ready handshake, but the block never applies back-pressure: `mw_ready` is held high, and a beat is consumed on every cycle `mw_valid` is high. A beat that arrives while an operation runs is consumed and discarded, and it raises the sequence error. Because ready never falls, the source needs no holding buffer.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Writing the control register with the go bit (bit 16) and the whole-array erase bit (bit 2) set erases every row to all ones. `busy` stays high for exactly MASS_CYC cycles (default 64).
- R2: When the whole-array erase bit and the sector-erase bit (bit 1) are both set with go, a whole-array erase is performed, not a sector erase.
- R3: A program ANDs the new bytes into the stored row. A later program can only clear further bits.
- R4: Go with only the sector-erase bit set erases the row selected by the sector field (bits 7:4) to all ones, leaves other rows unchanged and holds `busy` for SECT_CYC cycles (default 16).
- R5: When an accepted stream write and an erase command occur in the same cycle, the erase completes first and the program follows it. `busy` stays high for SECT_CYC+PROG_CYC cycles in total, and the write is checked against the control register as it stood before that cycle.
- R6: A write whose last byte would fall past the end of its 16-byte row (byte offset + size > 16) is dropped and sets the alignment flag (status bit 4). A write that ends exactly on the row end is performed.
- R7: A write whose size code (0 byte, 1 half-word, 2 word, 3 double word) differs from the width field (bits 9:8, same coding) is dropped and sets the width-mismatch flag (status bit 5).
- R8: A write while program-enable (bit 0) is clear is dropped and sets the sequence flag (status bit 6). This check takes priority over R7, and R7 takes priority over R6.
- R9: Go with neither erase bit set raises the sequence flag and starts no operation.
- R10: An accepted, rule-abiding write keeps `busy` (status bit 0) high for exactly PROG_CYC cycles (default 4), starting the cycle after acceptance.
- R11: While `busy` is high, stream writes and control-register writes are ignored: the array and the control readback keep their values, and the sequence flag is set.
- R12: Error flags stay set until software writes 1 to the flag's bit in the status register. Writing 0 leaves a flag unchanged.
- R13: After reset, `busy` is low, all flags and control fields are zero, and every row reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Control register readback (go bit reads 0) |
| stat_rd | output | 32 | Status readback: bit 0 busy, bits 4/5/6 alignment/width/sequence flags |
| mw_valid | input | 1 | Stream write beat present |
| mw_ready | output | 1 | Stream ready, always high |
| mw_addr | input | ADDR_W (8) | Byte address: row in upper bits, byte offset in low 4 bits |
| mw_size | input | 2 | Access size code |
| mw_data | input | 64 | Write data, least significant bytes used |
| rd_row | input | RAW (4) | Row selected for readback |
| rd_data | output | 128 | Content of the selected row |
| busy | output | 1 | An operation is in progress |

## Verification
Programming is exercised with word writes that overlay new data on already cleared bits, which separates a true AND from a plain overwrite or an OR. It is also exercised with a double-word write and a write that ends exactly at the row end, which separates an inclusive boundary test from an exclusive one. Rejected writes are sent with offsets that cross the row, sizes that differ from the width field, and program-enable clear, so each flag is shown to respond to its own cause only. Erases are issued as sector, both-bits and combined with a same-cycle write to a row holding zeros: the final row shows whether the erase really came first, and busy lengths tell the three operations apart.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ERASE = 2'd1, ST_PROG = 2'd2} op_state_e;

  // control register bit positions
  localparam int CB_PG     = 0;
  localparam int CB_SER    = 1;
  localparam int CB_MER    = 2;
  localparam int CB_SEC_LO = 4;
  localparam int CB_PSZ_LO = 8;
  localparam int CB_START  = 16;

  // status register bit positions
  localparam int SB_BUSY  = 0;
  localparam int SB_ALIGN = 4;
  localparam int SB_PAR   = 5;
  localparam int SB_SEQ   = 6;

  typedef struct packed {
    logic [3:0]  off;
    acc_size_e   size;
    logic [63:0] data;
  } prog_beat_t;
endpackage

// File: rtl/fpe_wr_check.sv
module fpe_wr_check
  import flash_pe_pkg::*;
#(
  parameter int ROW_BYTES = 16,
  parameter int OFF_W     = $clog2(ROW_BYTES)
) (
  input  logic             pg_en,
  input  acc_size_e        psize,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             seq_err,
  output logic             par_err,
  output logic             align_err
);
  logic [OFF_W+1:0] end_pos;
  logic             crosses;

  always_comb begin
    end_pos   = {2'b00, off} + (OFF_W+2)'(32'd1 << size);
    crosses   = (int'(end_pos) > ROW_BYTES);
    seq_err   = !pg_en;
    par_err   = pg_en && (size != psize);
    align_err = pg_en && (size == psize) && crosses;
  end
endmodule

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_load_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fpe_array.sv
module fpe_array
  import flash_pe_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ROW_W     = 128,
  parameter int ROW_BYTES = ROW_W / 8,
  parameter int RAW       = $clog2(ROWS),
  parameter int OFF_W     = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_all,
  input  logic             erase_one,
  input  logic [RAW-1:0]   erase_row,
  input  logic             prog_en,
  input  logic [RAW-1:0]   prog_row,
  input  logic [OFF_W-1:0] prog_off,
  input  acc_size_e        prog_size,
  input  logic [63:0]      prog_data,
  input  logic [RAW-1:0]   rd_row,
  output logic [ROW_W-1:0] rd_data,
  output logic             all_erased
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] prog_word;
  int               nb;
  int               rel;

  always_comb begin
    nb        = 1 << prog_size;
    rel       = 0;
    prog_word = mem[prog_row];
    for (int b = 0; b < ROW_BYTES; b++) begin
      rel = b - int'(prog_off);
      if (rel >= 0 && rel < nb)
        prog_word[b*8 +: 8] = mem[prog_row][b*8 +: 8] & prog_data[rel[2:0]*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '1;
    end else begin
      if (erase_all) begin
        for (int r = 0; r < ROWS; r++) mem[r] <= '1;
      end else if (erase_one) begin
        mem[erase_row] <= '1;
      end
      if (prog_en) mem[prog_row] <= prog_word;
    end
  end

  always_comb begin
    all_erased = 1'b1;
    for (int r = 0; r < ROWS; r++)
      if (mem[r] != '1) all_erased = 1'b0;
  end

  assign rd_data = mem[rd_row];

  p_prog_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem[$past(prog_row)] & ~$past(mem[prog_row])) == '0));

  p_mass_all_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> all_erased);

  p_sector_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_one && !prog_en) |=> (mem[$past(erase_row)] == '1));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && (erase_all || erase_one)));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int PROG_CYC = 4,
  parameter int SECT_CYC = 16,
  parameter int MASS_CYC = 64,
  parameter int RAW      = $clog2(ROWS),
  parameter int ADDR_W   = RAW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_waddr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       ctrl_rd,
  output logic [31:0]       stat_rd,
  input  logic              mw_valid,
  output logic              mw_ready,
  input  logic [ADDR_W-1:0] mw_addr,
  input  logic [1:0]        mw_size,
  input  logic [63:0]       mw_data,
  input  logic [RAW-1:0]    rd_row,
  output logic [127:0]      rd_data,
  output logic              busy
);
  localparam int ROW_W     = 128;
  localparam int ROW_BYTES = ROW_W / 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);
  localparam int MAXC      = MASS_CYC + SECT_CYC + PROG_CYC;
  localparam int CW        = $clog2(MAXC + 1);

  // control fields
  logic           pg_q, ser_q, mer_q;
  logic [RAW-1:0] sec_q;
  acc_size_e      psz_q;
  // sticky flags
  logic           err_align_q, err_par_q, err_seq_q;
  // operation state
  op_state_e      state_q;
  logic           er_mass_q;
  logic [RAW-1:0] er_row_q;
  logic           pend_q;
  logic [RAW-1:0] pr_row_q;
  prog_beat_t     pr_q;

  logic idle, ctrl_wr, stat_wr, start, w_mer, w_ser, erase_go, start_bad;
  logic mw_fire, c_seq, c_par, c_align, wr_ok;
  logic set_seq, set_par, set_align;
  logic tmr_load, tmr_expired, op_end;
  logic [CW-1:0] tmr_val;
  logic erase_all, erase_one, prog_en, all_erased;
  acc_size_e in_size;

  assign in_size   = acc_size_e'(mw_size);
  assign mw_ready  = 1'b1;
  assign idle      = (state_q == ST_IDLE);
  assign busy      = !idle;
  assign ctrl_wr   = reg_we && (reg_waddr == 1'b0);
  assign stat_wr   = reg_we && (reg_waddr == 1'b1);
  assign w_mer     = reg_wdata[CB_MER];
  assign w_ser     = reg_wdata[CB_SER];
  assign start     = ctrl_wr && idle && reg_wdata[CB_START];
  assign erase_go  = start && (w_mer || w_ser);
  assign start_bad = start && !(w_mer || w_ser);
  assign mw_fire   = mw_valid && mw_ready;

  fpe_wr_check #(.ROW_BYTES(ROW_BYTES), .OFF_W(OFF_W)) u_chk (
    .pg_en     (pg_q),
    .psize     (psz_q),
    .size      (in_size),
    .off       (mw_addr[OFF_W-1:0]),
    .seq_err   (c_seq),
    .par_err   (c_par),
    .align_err (c_align)
  );

  assign wr_ok     = mw_fire && idle && !c_seq && !c_par && !c_align;
  assign set_seq   = (ctrl_wr && !idle) || start_bad || (mw_fire && !idle) || (mw_fire && idle && c_seq);
  assign set_par   = mw_fire && idle && c_par;
  assign set_align = mw_fire && idle && c_align;

  assign op_end    = !idle && tmr_expired;
  assign erase_all = op_end && (state_q == ST_ERASE) && er_mass_q;
  assign erase_one = op_end && (state_q == ST_ERASE) && !er_mass_q;
  assign prog_en   = op_end && (state_q == ST_PROG);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CW'(PROG_CYC - 1);
    if (erase_go) begin
      tmr_load = 1'b1;
      tmr_val  = w_mer ? CW'(MASS_CYC - 1) : CW'(SECT_CYC - 1);
    end else if (wr_ok) begin
      tmr_load = 1'b1;
    end else if (op_end && (state_q == ST_ERASE) && pend_q) begin
      tmr_load = 1'b1;
    end
  end

  fpe_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  fpe_array #(.ROWS(ROWS), .ROW_W(ROW_W), .ROW_BYTES(ROW_BYTES), .RAW(RAW), .OFF_W(OFF_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_all  (erase_all),
    .erase_one  (erase_one),
    .erase_row  (er_row_q),
    .prog_en    (prog_en),
    .prog_row   (pr_row_q),
    .prog_off   (pr_q.off),
    .prog_size  (pr_q.size),
    .prog_data  (pr_q.data),
    .rd_row     (rd_row),
    .rd_data    (rd_data),
    .all_erased (all_erased)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      ser_q <= 1'b0;
      mer_q <= 1'b0;
      sec_q <= '0;
      psz_q <= SZ_B;
    end else if (ctrl_wr && idle) begin
      pg_q  <= reg_wdata[CB_PG];
      ser_q <= w_ser;
      mer_q <= w_mer;
      sec_q <= reg_wdata[CB_SEC_LO +: RAW];
      psz_q <= acc_size_e'(reg_wdata[CB_PSZ_LO +: 2]);
    end
  end

  // sticky flags, write-one-to-clear; a new event wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_align_q <= 1'b0;
      err_par_q   <= 1'b0;
      err_seq_q   <= 1'b0;
    end else begin
      err_align_q <= (err_align_q && !(stat_wr && reg_wdata[SB_ALIGN])) || set_align;
      err_par_q   <= (err_par_q   && !(stat_wr && reg_wdata[SB_PAR]))   || set_par;
      err_seq_q   <= (err_seq_q   && !(stat_wr && reg_wdata[SB_SEQ]))   || set_seq;
    end
  end

  // operation sequencing: an erase always runs ahead of a same-cycle program
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      er_mass_q <= 1'b0;
      er_row_q  <= '0;
      pend_q    <= 1'b0;
      pr_row_q  <= '0;
      pr_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (erase_go) begin
            state_q   <= ST_ERASE;
            er_mass_q <= w_mer;
            er_row_q  <= reg_wdata[CB_SEC_LO +: RAW];
          end else if (wr_ok) begin
            state_q <= ST_PROG;
          end
          if (wr_ok) begin
            pend_q   <= erase_go;
            pr_row_q <= mw_addr[ADDR_W-1:OFF_W];
            pr_q     <= '{off: mw_addr[OFF_W-1:0], size: in_size, data: mw_data};
          end
        end
        ST_ERASE: begin
          if (op_end) begin
            state_q <= pend_q ? ST_PROG : ST_IDLE;
            pend_q  <= 1'b0;
          end
        end
        ST_PROG: begin
          if (op_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_PG]  = pg_q;
    ctrl_rd[CB_SER] = ser_q;
    ctrl_rd[CB_MER] = mer_q;
    ctrl_rd[CB_SEC_LO +: RAW] = sec_q;
    ctrl_rd[CB_PSZ_LO +: 2]   = psz_q;
    stat_rd = '0;
    stat_rd[SB_BUSY]  = busy;
    stat_rd[SB_ALIGN] = err_align_q;
    stat_rd[SB_PAR]   = err_par_q;
    stat_rd[SB_SEQ]   = err_seq_q;
  end

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tmr_expired) |=> busy);

  p_mass_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go && w_mer) |=> (er_mass_q && state_q == ST_ERASE));

  p_start_noerase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (state_q == ST_IDLE && err_seq_q));

  p_cross_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_fire && idle && pg_q && in_size == psz_q &&
     (int'(mw_addr[OFF_W-1:0]) + (1 << in_size) > ROW_BYTES)) |=> (err_align_q && state_q == ST_IDLE));

  p_width_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_fire && idle && pg_q && in_size != psz_q) |=> (err_par_q && state_q == ST_IDLE));

  p_pg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_fire && idle && !pg_q) |=> err_seq_q);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !idle) |=> (err_seq_q && $stable(ctrl_rd)));

  p_sticky_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seq_q && !(stat_wr && reg_wdata[SB_SEQ])) |=> err_seq_q);
endmodule

// File: tb/flash_pe_ctrl_test.sv
`timescale 1ns/1ps
module flash_pe_ctrl_test;
  localparam int ROWS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic         reg_waddr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  ctrl_rd, stat_rd;
  logic         mw_valid = 1'b0;
  logic         mw_ready;
  logic [7:0]   mw_addr = '0;
  logic [1:0]   mw_size = '0;
  logic [63:0]  mw_data = '0;
  logic [3:0]   rd_row = '0;
  logic [127:0] rd_data;
  logic         busy;

  always #2.5 clk = ~clk;

  flash_pe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_size(mw_size), .mw_data(mw_data), .rd_row(rd_row),
    .rd_data(rd_data), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    int           kind;   // 0 row, 1 status, 2 control
    int           row;
    logic [127:0] val;
    string        tag;
  } item_t;
  item_t sb_q[$];

  logic [127:0] model [ROWS];

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.kind == 0) begin
          rd_row = 4'(it.row);
          #0.1;
          check(rd_data == it.val, it.tag, rd_data, it.val);
        end else if (it.kind == 1) begin
          check(stat_rd == it.val[31:0], it.tag, 128'(stat_rd), it.val);
        end else begin
          check(ctrl_rd == it.val[31:0], it.tag, 128'(ctrl_rd), it.val);
        end
      end
    end
  end

  task automatic exp_row(input int r, input string tag);
    sb_q.push_back('{kind: 0, row: r, val: model[r], tag: tag});
  endtask
  task automatic exp_stat(input logic [31:0] v, input string tag);
    sb_q.push_back('{kind: 1, row: 0, val: 128'(v), tag: tag});
  endtask
  task automatic exp_ctrl(input logic [31:0] v, input string tag);
    sb_q.push_back('{kind: 2, row: 0, val: 128'(v), tag: tag});
  endtask
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input bit pg, input bit ser, input bit mer,
                                     input int sec, input int psz, input bit go);
    logic [31:0] v = '0;
    v[0] = pg; v[1] = ser; v[2] = mer;
    v[7:4] = 4'(sec); v[9:8] = 2'(psz); v[16] = go;
    return v;
  endfunction

  // drivers: called at a negedge, return at the next negedge
  task automatic ctrl_w(input logic [31:0] v);
    reg_we = 1'b1; reg_waddr = 1'b0; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic stat_w(input logic [31:0] v);
    reg_we = 1'b1; reg_waddr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic mem_w(input logic [7:0] a, input int sz, input logic [63:0] d);
    mw_valid = 1'b1; mw_addr = a; mw_size = 2'(sz); mw_data = d;
    @(negedge clk);
    mw_valid = 1'b0;
  endtask
  task automatic ctrl_mem_w(input logic [31:0] v, input logic [7:0] a, input int sz, input logic [63:0] d);
    reg_we = 1'b1; reg_waddr = 1'b0; reg_wdata = v;
    mw_valid = 1'b1; mw_addr = a; mw_size = 2'(sz); mw_data = d;
    @(negedge clk);
    reg_we = 1'b0; mw_valid = 1'b0;
  endtask
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // bench-side program model: AND selected bytes into the row
  task automatic model_prog(input logic [7:0] a, input int sz, input logic [63:0] d);
    int r = int'(a[7:4]);
    int o = int'(a[3:0]);
    for (int k = 0; k < (1 << sz); k++)
      model[r][(o+k)*8 +: 8] = model[r][(o+k)*8 +: 8] & d[k*8 +: 8];
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    for (int r = 0; r < ROWS; r++) model[r] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check(busy == 1'b0, "R13 busy after reset", 128'(busy), 128'(0));
    exp_stat(32'h0, "R13 status after reset");
    exp_ctrl(32'h0, "R13 control after reset");
    exp_row(0, "R13 row0 erased");
    exp_row(15, "R13 row15 erased");
    settle();

    // R10 / R3 programming with word width
    ctrl_w(mk(1, 0, 0, 0, 2, 0));
    exp_ctrl(mk(1, 0, 0, 0, 2, 0), "R13 control readback");
    mem_w(8'h10, 2, 64'hA5A5_0F0F);
    count_busy(n);
    check(n == 4, "R10 program busy length", 128'(n), 128'(4));
    model_prog(8'h10, 2, 64'hA5A5_0F0F);
    exp_row(1, "R3 first program");
    settle();
    mem_w(8'h10, 2, 64'hFFFF_00FF);
    count_busy(n);
    model_prog(8'h10, 2, 64'hFFFF_00FF);
    exp_row(1, "R3 AND of old and new");
    check(model[1][31:0] == 32'hA5A5_000F, "R3 model sanity", 128'(model[1][31:0]), 128'(32'hA5A5_000F));
    mem_w(8'h24, 2, 64'h0);
    count_busy(n);
    model_prog(8'h24, 2, 64'h0);
    exp_row(2, "R3 row2 program at offset 4");
    settle();

    // R6 crossing the row end
    mem_w(8'h1E, 2, 64'h0);
    check(busy == 1'b0, "R6 crossing write starts nothing", 128'(busy), 128'(0));
    exp_stat(32'h10, "R6 alignment flag");
    exp_row(1, "R6 row unchanged");
    settle();
    repeat (3) @(negedge clk);
    exp_stat(32'h10, "R12 flag stays set");
    settle();
    stat_w(32'h0);
    exp_stat(32'h10, "R12 writing zero keeps flag");
    settle();
    stat_w(32'h10);
    exp_stat(32'h0, "R12 write-one clears flag");
    settle();
    mem_w(8'h1C, 2, 64'h0000_FFFF);
    count_busy(n);
    check(n == 4, "R6 write ending on row end is performed", 128'(n), 128'(4));
    model_prog(8'h1C, 2, 64'h0000_FFFF);
    exp_row(1, "R6 boundary write content");
    exp_stat(32'h0, "R6 no flag at exact end");
    settle();

    // R7 width mismatch
    mem_w(8'h30, 0, 64'h0);
    exp_stat(32'h20, "R7 width flag");
    exp_row(3, "R7 row unchanged");
    settle();
    stat_w(32'h20);
    ctrl_w(mk(1, 0, 0, 0, 3, 0));
    mem_w(8'h38, 3, 64'h0123_4567_89AB_CDEF);
    count_busy(n);
    model_prog(8'h38, 3, 64'h0123_4567_89AB_CDEF);
    exp_row(3, "R3 double-word program");
    settle();
    mem_w(8'h3C, 3, 64'h0);
    exp_stat(32'h10, "R6 double-word crossing");
    exp_row(3, "R6 row3 unchanged");
    settle();
    stat_w(32'h10);

    // R8 program-enable clear
    ctrl_w(mk(0, 0, 0, 0, 2, 0));
    mem_w(8'h40, 0, 64'h0);
    exp_stat(32'h40, "R8 sequence flag with width also wrong");
    exp_row(4, "R8 row unchanged");
    settle();
    stat_w(32'h40);

    // R9 go without an erase bit
    ctrl_w(mk(0, 0, 0, 0, 2, 1));
    check(busy == 1'b0, "R9 no operation started", 128'(busy), 128'(0));
    exp_stat(32'h40, "R9 sequence flag");
    exp_ctrl(mk(0, 0, 0, 0, 2, 0), "R9 control fields stored");
    settle();
    stat_w(32'h40);

    // R4 sector erase
    ctrl_w(mk(0, 1, 0, 1, 2, 1));
    count_busy(n);
    check(n == 16, "R4 sector erase busy length", 128'(n), 128'(16));
    model[1] = '1;
    exp_row(1, "R4 selected row erased");
    exp_row(2, "R4 other row kept");
    settle();

    // R11 activity while busy
    ctrl_w(mk(1, 1, 0, 2, 2, 1));
    mem_w(8'h50, 2, 64'h0);
    ctrl_w(mk(1, 0, 0, 0, 0, 0));
    count_busy(n);
    check(n + 2 == 16, "R11 busy unaffected by ignored writes", 128'(n + 2), 128'(16));
    model[2] = '1;
    exp_stat(32'h40, "R11 sequence flag");
    exp_ctrl(mk(1, 1, 0, 2, 2, 0), "R11 control write ignored");
    exp_row(5, "R11 stream write ignored");
    exp_row(2, "R11 erase still done");
    settle();
    stat_w(32'h40);

    // R5 erase and program in the same cycle
    ctrl_w(mk(1, 0, 0, 0, 2, 0));
    mem_w(8'h30, 2, 64'h0);
    count_busy(n);
    model_prog(8'h30, 2, 64'h0);
    exp_row(3, "R5 row3 preloaded");
    settle();
    ctrl_mem_w(mk(1, 1, 0, 3, 2, 1), 8'h30, 2, 64'h1234_5678);
    count_busy(n);
    check(n == 20, "R5 erase then program busy length", 128'(n), 128'(20));
    model[3] = '1;
    model_prog(8'h30, 2, 64'h1234_5678);
    exp_row(3, "R5 erase first then program");
    exp_stat(32'h0, "R5 no flags");
    settle();

    // R1 / R2 whole-array erase with both bits
    ctrl_w(mk(0, 1, 1, 5, 2, 1));
    count_busy(n);
    check(n == 64, "R2 both bits give whole-array erase", 128'(n), 128'(64));
    for (int r = 0; r < ROWS; r++) model[r] = '1;
    for (int r = 0; r < ROWS; r++) exp_row(r, "R1 every row erased");
    exp_stat(32'h0, "R1 busy clear after erase");
    settle();

    // R1 whole-array erase alone, after dirtying a row
    ctrl_w(mk(1, 0, 0, 0, 2, 0));
    mem_w(8'hF0, 2, 64'h0);
    count_busy(n);
    ctrl_w(mk(0, 0, 1, 0, 2, 1));
    count_busy(n);
    check(n == 64, "R1 whole-array erase busy length", 128'(n), 128'(64));
    exp_row(15, "R1 row15 erased");
    settle();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule